// File: doc/BRIEF.md
# Indirect Dword Register Window

This block gives configuration-space software a narrow, two-dword capability through which it can read and write any dword of a larger register space. Software writes a dword index into a one-byte selector, then reads the mirrored dword from the capability's data word, or writes that data word to push a new value into the selected register-space dword. The register space behind the window is outside this block. It answers a combinational read port with the addressed dword and with two per-bit masks for that dword: a plain write mask and a write-1-to-clear mask. The window applies both masks itself and sends back a fully merged dword.

Every configuration write to the capability starts a short sequence in a three-state machine. `ST_IDLE` accepts configuration writes. A write that carries at least one enabled byte of the data word takes the `IDLE_TO_APPLY` transition. Any other capability write takes `IDLE_TO_RELOAD`. `ST_APPLY` issues the merged write to the selected dword and always takes `APPLY_TO_RELOAD`. `ST_RELOAD` copies the selected dword, now updated, into the data word and takes `RELOAD_TO_IDLE`. The data word therefore mirrors the register space after every capability write. A selector that points past the implemented register space forwards nothing and mirrors zero.

The capability's first dword holds an identifier byte and a next-pointer byte, both fixed by parameters, at bits 7:0 and 15:8. The selector sits at bits 23:16. Bits 31:24 form a status byte that reads zero. The second dword is the data word.

Top module: `dword_window`

## Requirements
- R1: After reset the selector, the status byte and the data word are all zero, and `win_data` reads zero.
- R2: A configuration read with `cfg_addr`=0 returns {8'h00, selector, NEXT_PTR, CAP_ID}, and with `cfg_addr`=1 returns the data word, one cycle after `cfg_rd`.
- R3: A write with `cfg_addr`=0 and `cfg_be[2]` set loads `cfg_wdata[23:16]` into the selector. Two clock edges after that write, the data word holds the register-space dword at byte address selector×4, which is driven on `rs_addr`.
- R4: A write with `cfg_addr`=1 and any `cfg_be` bit set issues exactly one `rs_wr` pulse, one cycle after the write, at `rs_addr` = selector×4 and carrying the full 32-bit data word.
- R5: For each bit of the forwarded dword, the result is (old AND NOT wmask) OR (val AND wmask), and then the bit is cleared where val AND w1cmask is 1. Here old is `rs_rdata` and val is the data word.
- R6: Three clock edges after a forwarding data write, the data word holds the register-space dword as it stands after that write.
- R7: If the selector is at or beyond RS_BYTES/4, a data write issues no `rs_wr`, and the data word reloads as zero.
- R8: On a data write, only the bytes enabled by `cfg_be` are taken into the data word. On the first dword, bytes 0, 1 and 3 ignore writes.
- R9: Any capability write, even one that changes no field, reloads the data word from the selected dword two edges later.
- R10: A capability write that enables no data-word byte causes no `rs_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe to the capability |
| cfg_rd | input | 1 | Configuration read strobe to the capability |
| cfg_addr | input | 1 | Capability dword: 0 header and selector, 1 data word |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, registered |
| rs_addr | output | SEL_W+2 | Register-space byte address (selector×4) |
| rs_wr | output | 1 | Register-space write strobe |
| rs_wdata | output | 32 | Merged dword to write |
| rs_rdata | input | 32 | Register-space dword at `rs_addr`, combinational |
| rs_wmask | input | 32 | Writable-bit mask of that dword |
| rs_w1cmask | input | 32 | Write-1-to-clear mask of that dword |
| win_data | output | 32 | Current mirrored data word |

## Verification
The assertions assume that a configuration write arrives only while the machine is idle. A write must therefore be followed by at least two idle cycles before the next write. Every bench task waits for the reload to finish before it writes, reads or checks anything. The assertions also take the register-space read port to be combinational and in step with `rs_addr`. The bench models it that way and returns a junk value for addresses past the implemented size, so any mirroring of an out-of-range dword is detected.

// File: rtl/dwin_pkg.sv
package dwin_pkg;

    localparam int DWORD_W = 32;
    localparam int LANES   = DWORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_RELOAD = 2'd2
    } win_state_e;

    // One byte lane of the masked merge: plain writes first, then W1C clear.
    function automatic logic [7:0] merge_lane(
        input logic [7:0] old_b,
        input logic [7:0] val_b,
        input logic [7:0] wm_b,
        input logic [7:0] w1c_b
    );
        logic [7:0] t;
        t = (old_b & ~wm_b) | (val_b & wm_b);
        return t & ~(val_b & w1c_b);
    endfunction

endpackage

// File: rtl/dwin_merge.sv
module dwin_merge
    import dwin_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [NLANES*8-1:0] old_i,
    input  logic [NLANES*8-1:0] val_i,
    input  logic [NLANES*8-1:0] wmask_i,
    input  logic [NLANES*8-1:0] w1c_i,
    output logic [NLANES*8-1:0] merged_o
);

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign merged_o[g*8 +: 8] = merge_lane(old_i[g*8 +: 8], val_i[g*8 +: 8],
                                               wmask_i[g*8 +: 8], w1c_i[g*8 +: 8]);
    end

endmodule

// File: rtl/dwin_cap_regs.sv
module dwin_cap_regs
    import dwin_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_wr,
    input  logic               dat_wr,
    input  logic [LANES-1:0]   be,
    input  logic [DWORD_W-1:0] wdata,
    input  logic               load_en,
    input  logic [DWORD_W-1:0] load_val,
    output logic [SEL_W-1:0]   sel_q,
    output logic [DWORD_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (hdr_wr && be[2]) begin
            sel_q <= wdata[16 +: SEL_W];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_data_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g*8 +: 8] <= '0;
            end else if (dat_wr && be[g]) begin
                data_q[g*8 +: 8] <= wdata[g*8 +: 8];
            end else if (load_en) begin
                data_q[g*8 +: 8] <= load_val[g*8 +: 8];
            end
        end
    end

    // R3/R6: the data word moves only on a data write or a reload.
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dat_wr && !load_en) |=> $stable(data_q));

    // R8: the selector moves only on a header write that enables byte 2.
    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_wr && be[2]) |=> $stable(sel_q));

endmodule

// File: rtl/dwin_fsm.sv
module dwin_fsm
    import dwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_wr,
    input  logic       dat_hit,
    input  logic       in_range,
    output logic       fwd_wr,
    output logic       reload_en,
    output win_state_e state_o
);

    win_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cap_wr) state_d = dat_hit ? ST_APPLY : ST_RELOAD;
            end
            ST_APPLY:  state_d = ST_RELOAD;
            ST_RELOAD: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fwd_wr    = 1'b0;
        reload_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_APPLY:  fwd_wr    = in_range;
            ST_RELOAD: reload_en = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state_q;

    // R9: configuration writes are only accepted while idle (input assumption).
    assert_wr_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |-> state_q == ST_IDLE);

    // R6: a forward is always followed by a reload.
    assert_fwd_then_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr |=> reload_en);

endmodule

// File: rtl/dword_window.sv
module dword_window
    import dwin_pkg::*;
#(
    parameter int          SEL_W    = 8,
    parameter int          RS_BYTES = 32,
    parameter logic [7:0]  CAP_ID   = 8'h0C,
    parameter logic [7:0]  NEXT_PTR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic               cfg_addr,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic [SEL_W+1:0]   rs_addr,
    output logic               rs_wr,
    output logic [31:0]        rs_wdata,
    input  logic [31:0]        rs_rdata,
    input  logic [31:0]        rs_wmask,
    input  logic [31:0]        rs_w1cmask,
    output logic [31:0]        win_data
);

    localparam int RS_DWORDS = RS_BYTES / 4;

    logic [SEL_W-1:0]   sel_q;
    logic [DWORD_W-1:0] data_q;
    logic               hdr_wr, dat_wr, dat_hit, in_range;
    logic               fwd_wr, reload_en;
    logic [DWORD_W-1:0] load_val;
    logic [DWORD_W-1:0] merged;
    win_state_e         state;

    assign hdr_wr   = cfg_wr && !cfg_addr;
    assign dat_wr   = cfg_wr &&  cfg_addr;
    assign dat_hit  = dat_wr && (|cfg_be);
    assign in_range = (int'(sel_q) < RS_DWORDS);
    assign load_val = in_range ? rs_rdata : '0;

    dwin_cap_regs #(.SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_wr   (hdr_wr),
        .dat_wr   (dat_wr),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .load_en  (reload_en),
        .load_val (load_val),
        .sel_q    (sel_q),
        .data_q   (data_q)
    );

    dwin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_wr    (cfg_wr),
        .dat_hit   (dat_hit),
        .in_range  (in_range),
        .fwd_wr    (fwd_wr),
        .reload_en (reload_en),
        .state_o   (state)
    );

    dwin_merge #(.NLANES(LANES)) u_merge (
        .old_i    (rs_rdata),
        .val_i    (data_q),
        .wmask_i  (rs_wmask),
        .w1c_i    (rs_w1cmask),
        .merged_o (merged)
    );

    assign rs_addr  = {sel_q, 2'b00};
    assign rs_wr    = fwd_wr;
    assign rs_wdata = merged;
    assign win_data = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= cfg_addr ? data_q
                                  : {8'h00, {(8-SEL_W){1'b0}}, sel_q, NEXT_PTR, CAP_ID};
        end
    end

    // R7: no register-space write ever targets an unimplemented address.
    assert_fwd_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rs_wr |-> (int'(rs_addr) < RS_BYTES));

    // R4: every register-space write is caused by a data-word write one cycle earlier.
    assert_fwd_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_wr |-> $past(cfg_wr && cfg_addr && (|cfg_be)));

    // R7: reloading through an out-of-range selector mirrors zero.
    assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_en && !in_range) |=> win_data == '0);

    // R10: a write without data-byte enables leads straight to reload, never to a forward.
    assert_no_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !dat_hit) |=> (state == ST_RELOAD && !rs_wr));

endmodule

// File: tb/dword_window_tb_top.sv
module dword_window_tb_top;

    localparam int SEL_W = 8;
    localparam int RS_BYTES = 32;
    localparam int RS_DW = RS_BYTES / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_addr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [SEL_W+1:0] rs_addr;
    logic        rs_wr;
    logic [31:0] rs_wdata, rs_rdata, rs_wmask, rs_w1cmask, win_data;

    int tests = 0;
    int fails = 0;
    int wr_count = 0;
    logic [31:0] mem [RS_DW];

    always #4 clk = ~clk;   // 125 MHz

    dword_window #(.SEL_W(SEL_W), .RS_BYTES(RS_BYTES), .CAP_ID(8'h0C), .NEXT_PTR(8'h00)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rs_addr(rs_addr),
        .rs_wr(rs_wr), .rs_wdata(rs_wdata), .rs_rdata(rs_rdata), .rs_wmask(rs_wmask),
        .rs_w1cmask(rs_w1cmask), .win_data(win_data)
    );

    // Register-space model: dword 2 read-only, odd dwords fully writable,
    // other even dwords writable low 24 bits with W1C on the top byte.
    function automatic logic [31:0] wm_of(int i);
        if (i == 2) return 32'h0;
        if (i % 2 == 1) return 32'hFFFF_FFFF;
        return 32'h00FF_FFFF;
    endfunction
    function automatic logic [31:0] w1c_of(int i);
        if (i == 2 || i % 2 == 1) return 32'h0;
        return 32'hFF00_0000;
    endfunction
    function automatic logic [31:0] exp_merge(logic [31:0] o, logic [31:0] v, int i);
        logic [31:0] t;
        t = (o & ~wm_of(i)) | (v & wm_of(i));
        return t & ~(v & w1c_of(i));
    endfunction

    always_comb begin
        int idx;
        idx = int'(rs_addr) / 4;
        if (idx < RS_DW) begin
            rs_rdata = mem[idx]; rs_wmask = wm_of(idx); rs_w1cmask = w1c_of(idx);
        end else begin
            rs_rdata = 32'hDEAD_BEEF; rs_wmask = '1; rs_w1cmask = '0;
        end
    end

    always @(posedge clk) begin
        if (rs_wr) begin
            wr_count <= wr_count + 1;
            if (int'(rs_addr) / 4 < RS_DW) mem[int'(rs_addr) / 4] <= rs_wdata;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_read(logic a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic select(int s);
        cfg_write(1'b0, 4'b0100, {8'h00, 8'(s), 16'h0});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 win_data after reset", win_data, 32'h0);
        cfg_read(1'b0, d); chk("R1 R2 header after reset", d, 32'h0000_000C);
        cfg_read(1'b1, d); chk("R1 data after reset", d, 32'h0);
    endtask

    task automatic t_select_reload();
        logic [31:0] d;
        int c0;
        c0 = wr_count;
        select(1);
        chk("R3 mirror of dword 1", win_data, mem[1]);
        chk("R10 no write on select", 32'(wr_count - c0), 32'd0);
        cfg_read(1'b0, d); chk("R2 header with select 1", d, 32'h0001_000C);
        cfg_read(1'b1, d); chk("R2 data read", d, mem[1]);
    endtask

    task automatic t_forward_full();
        int c0;
        c0 = wr_count;
        cfg_write(1'b1, 4'hF, 32'h1234_5678);
        chk("R4 one write pulse", 32'(wr_count - c0), 32'd1);
        chk("R4 R5 dword 1 written", mem[1], 32'h1234_5678);
        chk("R6 mirror after forward", win_data, 32'h1234_5678);
    endtask

    task automatic t_w1c_merge();
        logic [31:0] e;
        mem[0] = 32'hF0AA_BBCC;
        select(0);
        chk("R3 mirror of dword 0", win_data, 32'hF0AA_BBCC);
        e = exp_merge(32'hF0AA_BBCC, 32'h3011_2233, 0);
        cfg_write(1'b1, 4'hF, 32'h3011_2233);
        chk("R5 masked merge with W1C", mem[0], e);
        chk("R5 expected constant", e, 32'hC011_2233);
        chk("R6 mirror shows cleared bits", win_data, e);
    endtask

    task automatic t_partial_be();
        logic [31:0] old, e;
        select(1);
        old = win_data;
        e = {old[31:16], 16'h9999};
        cfg_write(1'b1, 4'b0011, 32'hFFFF_9999);
        chk("R8 partial byte enables", mem[1], e);
        chk("R8 mirror after partial", win_data, e);
    endtask

    task automatic t_readonly();
        logic [31:0] old;
        int c0;
        select(2);
        old = mem[2];
        c0 = wr_count;
        cfg_write(1'b1, 4'hF, 32'h5555_AAAA);
        chk("R4 write issued to read-only dword", 32'(wr_count - c0), 32'd1);
        chk("R5 read-only dword unchanged", mem[2], old);
        chk("R6 mirror reloaded with old value", win_data, old);
    endtask

    task automatic t_out_of_range();
        int c0;
        select(RS_DW);
        chk("R7 mirror zero at first unimplemented dword", win_data, 32'h0);
        c0 = wr_count;
        cfg_write(1'b1, 4'hF, 32'hCAFE_F00D);
        chk("R7 no write out of range", 32'(wr_count - c0), 32'd0);
        chk("R7 mirror reloads zero", win_data, 32'h0);
        select(255);
        chk("R7 mirror zero at top select", win_data, 32'h0);
    endtask

    task automatic t_header_refresh();
        logic [31:0] d;
        int c0;
        select(3);
        mem[3] = 32'h0BAD_CAFE;
        c0 = wr_count;
        cfg_write(1'b0, 4'b1011, 32'hFFFF_FFFF);
        chk("R9 refresh on header-only write", win_data, 32'h0BAD_CAFE);
        chk("R10 no write on header write", 32'(wr_count - c0), 32'd0);
        cfg_read(1'b0, d); chk("R8 read-only header bytes", d, 32'h0003_000C);
        mem[3] = 32'h7777_1111;
        cfg_write(1'b1, 4'b0000, 32'hFFFF_FFFF);
        chk("R10 no write when data bytes disabled", 32'(wr_count - c0), 32'd0);
        chk("R9 refresh on empty data write", win_data, 32'h7777_1111);
    endtask

    initial begin
        for (int i = 0; i < RS_DW; i++)
            mem[i] = {8'(8'hC0 + i), 8'h5A, 8'(i), 8'h3C};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select_reload();
        t_forward_full();
        t_w1c_merge();
        t_partial_be();
        t_readonly();
        t_out_of_range();
        t_header_refresh();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule